// File: doc/BRIEF.md
# Scanline Address-Bit Edge Filter

This block turns a noisy address bit from the picture-memory bus, whose rising edges mark scanline boundaries, into a clean level and a single-cycle rising-edge strobe for a downstream scanline counter. It runs entirely in one fast system clock domain. The raw address bit and the CPU bus clock both arrive asynchronously and pass through flop synchronisers before use.

The first stage is a glitch rejector on the fast clock. It keeps a short window of recent samples and moves its output only when the whole window agrees. The second stage is a delay line. It advances only on falling edges of the bus clock, which are detected in the fast domain and used as an enable rather than as a clock. The filtered level rises one bus fall late and falls only after a run of consecutive low samples. A one-cycle pulse marks every rise of the filtered level.

Top module: `scan_edge_filter`

## Requirements
- R1: While rst_ni is low, pre_level_o, level_o and rise_o are 0, and every internal history reads as 0 once reset is released.
- R2: pre_level_o becomes 1 only after GLITCH_LEN (default 2) consecutive synchronised samples of line_i are 1, becomes 0 only after GLITCH_LEN consecutive samples are 0, and otherwise holds.
- R3: A pulse on line_i shorter than GLITCH_LEN fast-clock periods never changes pre_level_o or level_o.
- R4: level_o changes only in the cycle after a falling edge of bus_clk_i has been detected; with bus_clk_i held steady, level_o does not move whatever line_i does.
- R5: With default parameters, after pre_level_o rises, level_o stays 0 through the first bus-clock fall that samples it high and becomes 1 at the second such fall.
- R6: With default parameters, level_o falls only at the fourth consecutive bus-clock fall that samples pre_level_o low; a low run of fewer falls leaves level_o at 1.
- R7: rise_o is a single fast-clock pulse, high exactly in the cycle in which level_o goes from 0 to 1, and never in any other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_clk_i | input | 1 | CPU bus clock, asynchronous; its falling edges advance the delay line |
| line_i | input | 1 | Raw scanline address bit, asynchronous |
| pre_level_o | output | 1 | Output of the glitch rejector |
| level_o | output | 1 | Filtered level after the bus-clock delay line |
| rise_o | output | 1 | One-cycle strobe on each 0-to-1 step of level_o |

## Verification
The address bit is driven with one-cycle and two-cycle pulses, which separate a rejected glitch from the shortest accepted change, and with long high and low runs under a running bus clock, which expose the one-fall rise delay and the four-fall release. Short low dips of two bus falls tell a correct release count from one that drops early. Holding the bus clock high while the line toggles shows whether the delay line advances without a bus fall, and a mid-run reset shows that all history is cleared.

// File: rtl/sef_pkg.sv
package sef_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned GLITCH_LEN_DEF  = 2;
  localparam int unsigned LINE_LEN_DEF    = 4;
  localparam int unsigned LINE_DLY_DEF    = 1;
endpackage

// File: rtl/sef_sync.sv
module sef_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sef_glitch.sv
module sef_glitch #(
  parameter int unsigned WIN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [WIN-1:0] win_q;
  logic           lvl_q;

  generate
    if (WIN == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) win_q <= '0;
        else         win_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) win_q <= '0;
        else         win_q <= {win_q[WIN-2:0], d_i};
    end
  endgenerate

  // level moves only when the whole window agrees
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          lvl_q <= 1'b0;
    else if (&win_q)      lvl_q <= 1'b1;
    else if (~|win_q)     lvl_q <= 1'b0;
  end

  assign q_o = lvl_q;
endmodule

// File: rtl/sef_delay.sv
module sef_delay #(
  parameter int unsigned LEN = 4,
  parameter int unsigned DLY = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic lvl_o
);
  logic [LEN-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   line_q <= '0;
    else if (en_i) line_q <= {line_q[LEN-2:0], d_i};
  end

  // taps DLY..LEN-1: late rise, long hold
  assign lvl_o = |line_q[LEN-1:DLY];
endmodule

// File: rtl/scan_edge_filter.sv
module scan_edge_filter
  import sef_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  parameter int unsigned GLITCH_LEN  = GLITCH_LEN_DEF,
  parameter int unsigned LINE_LEN    = LINE_LEN_DEF,
  parameter int unsigned LINE_DLY    = LINE_DLY_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_clk_i,
  input  logic line_i,
  output logic pre_level_o,
  output logic level_o,
  output logic rise_o
);
  logic line_sync;
  logic bus_sync;
  logic bus_prev_q;
  logic bus_fall;
  logic pre_lvl;
  logic lvl;
  logic lvl_q;

  sef_sync #(.STAGES(SYNC_STAGES)) u_sync_line (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(line_sync)
  );

  sef_sync #(.STAGES(SYNC_STAGES)) u_sync_bus (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bus_clk_i), .q_o(bus_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_prev_q <= 1'b0;
      lvl_q      <= 1'b0;
    end else begin
      bus_prev_q <= bus_sync;
      lvl_q      <= lvl;
    end
  end

  assign bus_fall = bus_prev_q & ~bus_sync;

  sef_glitch #(.WIN(GLITCH_LEN)) u_glitch (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_sync), .q_o(pre_lvl)
  );

  sef_delay #(.LEN(LINE_LEN), .DLY(LINE_DLY)) u_delay (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(bus_fall), .d_i(pre_lvl), .lvl_o(lvl)
  );

  assign pre_level_o = pre_lvl;
  assign level_o     = lvl;
  assign rise_o      = lvl & ~lvl_q;
endmodule

// File: rtl/scan_edge_filter_chk.sv
module scan_edge_filter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic line_sync,
  input logic bus_fall,
  input logic pre_level_o,
  input logic level_o,
  input logic rise_o
);
  assert_pre_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pre_level_o) |-> ($past(line_sync, 2) && $past(line_sync, 3)));

  assert_pre_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pre_level_o) |-> (!$past(line_sync, 2) && !$past(line_sync, 3)));

  assert_level_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o != $past(level_o)) |-> $past(bus_fall));

  assert_rise_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

  assert_rise_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (level_o && !$past(level_o)));
endmodule

bind scan_edge_filter scan_edge_filter_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .line_sync(line_sync), .bus_fall(bus_fall),
  .pre_level_o(pre_level_o), .level_o(level_o), .rise_o(rise_o)
);

// File: tb/scan_edge_filter_tb.sv
module scan_edge_filter_tb;
  localparam int LEN = 4;
  localparam int DLY = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_clk = 1'b0;
  logic line = 1'b0;
  logic pre_level, level, rise;

  int checks = 0;
  int errors = 0;
  int rise_cnt = 0;

  always #2 clk = ~clk;

  scan_edge_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_clk_i(bus_clk), .line_i(line),
    .pre_level_o(pre_level), .level_o(level), .rise_o(rise)
  );

  // behavioural reference: sample histories, newest at index 0
  bit xq[$];
  bit mq[$];
  bit bq[$];
  bit pre_m, lvl_m, lvl_prev_m, rise_m;

  task automatic model_clear();
    xq.delete(); mq.delete(); bq.delete();
    for (int i = 0; i < 8; i++) begin xq.push_back(1'b0); mq.push_back(1'b0); end
    for (int i = 0; i < LEN; i++) bq.push_back(1'b0);
    pre_m = 0; lvl_m = 0; lvl_prev_m = 0; rise_m = 0;
  endtask

  initial model_clear();

  always @(posedge clk) begin
    if (!rst_n) model_clear();
    else begin
      bit pre_before;
      bit any;
      xq.push_front(line);  void'(xq.pop_back());
      mq.push_front(bus_clk); void'(mq.pop_back());
      pre_before = pre_m;
      if (xq[3] == xq[4]) pre_m = xq[3];
      if (mq[3] && !mq[2]) begin
        bq.push_front(pre_before);
        void'(bq.pop_back());
      end
      any = 0;
      for (int i = DLY; i < LEN; i++) any |= bq[i];
      lvl_prev_m = lvl_m;
      lvl_m = any;
      rise_m = lvl_m & ~lvl_prev_m;
    end
  end

  task automatic chk(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(pre_level, pre_m, "R2 pre_level per-cycle");
      chk(level, lvl_m, "R5/R6 level per-cycle");
      chk(rise, rise_m, "R7 rise per-cycle");
      if (rise) rise_cnt++;
    end
  end

  task automatic clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_cycle();
    bus_clk = 1'b1; clks(8);
    bus_clk = 1'b0; clks(8);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clks(3);
    chk(pre_level, 1'b0, "R1 reset pre");
    chk(level, 1'b0, "R1 reset level");
    chk(rise, 1'b0, "R1 reset rise");
    rst_n = 1'b1;
    clks(4);

    // R3: one-cycle pulse is rejected
    line = 1'b1; clks(1); line = 1'b0; clks(10);
    chk(pre_level, 1'b0, "R3 single-cycle pulse ignored");
    bus_cycle(); bus_cycle();
    chk(level, 1'b0, "R3 glitch never reaches level");

    // R2: two-cycle pulse is the shortest accepted
    line = 1'b1; clks(2); line = 1'b0; clks(4);
    chk(pre_level, 1'b1, "R2 two-cycle pulse accepted");
    clks(6);
    chk(pre_level, 1'b0, "R2 pre falls after low window");

    // R4: bus clock held high, line moves, level frozen
    bus_clk = 1'b1; clks(4);
    line = 1'b1; clks(30);
    chk(pre_level, 1'b1, "R4 pre follows line");
    chk(level, 1'b0, "R4 level frozen without bus fall");
    line = 1'b0; clks(20);
    bus_clk = 1'b0; clks(8);
    chk(level, 1'b0, "R4 level still low");

    // R5: rise delayed by one bus fall
    rise_cnt = 0;
    line = 1'b1; clks(8);
    bus_cycle();
    chk(level, 1'b0, "R5 level low after first high fall");
    bus_cycle();
    chk(level, 1'b1, "R5 level high at second high fall");
    chk(rise_cnt == 1, 1'b1, "R7 one rise pulse");

    // R6: release needs four low falls
    line = 1'b0; clks(8);
    bus_cycle(); bus_cycle(); bus_cycle();
    chk(level, 1'b1, "R6 level held after three low falls");
    bus_cycle();
    chk(level, 1'b0, "R6 level low after fourth low fall");

    // R6: short dip does not release
    line = 1'b1; clks(8); bus_cycle(); bus_cycle();
    line = 1'b0; clks(8); bus_cycle(); bus_cycle();
    line = 1'b1; clks(8); bus_cycle();
    chk(level, 1'b1, "R6 two-fall dip keeps level");
    chk(rise_cnt == 2, 1'b1, "R7 pulse count after dip");

    // R1: reset mid-run clears everything
    clks(3);
    rst_n = 1'b0; clks(1);
    chk(level, 1'b0, "R1 mid-run reset level");
    chk(pre_level, 1'b0, "R1 mid-run reset pre");
    line = 1'b0; clks(3);
    rst_n = 1'b1; clks(2);
    bus_cycle(); bus_cycle();
    chk(level, 1'b0, "R1 history cleared");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule